// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation buffer with a parameterized number of entries. Each entry maps two neighbouring virtual pages, one even and one odd. The two pages share one tag, and each has its own frame number and its own dirty and valid bits. A per-entry page-size field sets the size of both pages, from 4 KB up to 64 MB in steps of four.

Entries are loaded through a one-cycle write port. A loaded entry is visible to lookups from the next cycle onward. The lookup port is purely combinational. It takes a virtual address, the current address-space identifier, a store flag and a quiet flag. In the same cycle it returns either a hit or a fault. A hit comes with a physical address and a writable flag. A fault comes with an exception code and a refill indication. When the quiet flag is set, a failed lookup reports only that it missed.

Top module: `tlbp_lookup`

## Requirements
- R1: Reset clears every entry to all zeros. A read lookup of address 0x123 with ASID 0 after reset therefore reports TLB-invalid, with code 2 and refill low. A store lookup of the same address reports code 3.
- R2: The page-size field `wr_mask` (14 bits, one per address bit 13..26) gives the page shift. A field of 2k contiguous low ones gives shift 12+2k, for k = 1..7. A zero field gives shift 12. Any other value is treated as shift 12.
- R3: Tag comparison covers only virtual address bits above the page shift plus one. Field bit i of `wr_vpn2` stands for address bit i+13, and field bits standing for address bits at or below the shift are ignored.
- R4: Address bit [page shift] selects the odd half of the entry when it is 1 and the even half when it is 0.
- R5: An entry matches only when its tag matches and either its ASID equals `lk_asid` or its global bit is set.
- R6: A successful lookup sets `lk_hit`. It returns the selected frame number shifted left by 12, ORed with the address bits below the page shift. `lk_writable` equals the selected dirty bit.
- R7: A matched entry whose selected valid bit is clear raises a non-refill fault. The code is 2 for a read and 3 for a store.
- R8: A store to a matched, valid page whose dirty bit is clear raises a modification fault with code 1 and refill low. A read of the same page hits.
- R9: When no entry matches, the block raises a refill fault. The code is 2 for a read and 3 for a store, and `lk_refill` is high.
- R10: With `lk_quiet` set, a failed lookup drives `lk_hit`, `lk_exc`, `lk_refill` and the code (0) low. A lookup that would succeed is unaffected.
- R11: When several entries match, the lowest-indexed one supplies the result.
- R12: A write-port pulse replaces the whole entry at `wr_idx`, and lookups see the new contents from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry on this edge |
| wr_idx | input | IDX_W | Entry index to load |
| wr_mask | input | 14 | Page-size field |
| wr_vpn2 | input | 19 | Tag: virtual address bits 31..13 |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_global | input | 1 | Entry matches any ASID |
| wr_pfn_even | input | 24 | Frame number, even page |
| wr_dirty_even | input | 1 | Even page writable |
| wr_valid_even | input | 1 | Even page present |
| wr_pfn_odd | input | 24 | Frame number, odd page |
| wr_dirty_odd | input | 1 | Odd page writable |
| wr_valid_odd | input | 1 | Odd page present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | Access is a store |
| lk_quiet | input | 1 | Suppress fault reporting |
| lk_hit | output | 1 | Translation succeeded |
| lk_paddr | output | 36 | Physical address (zero when no hit) |
| lk_writable | output | 1 | Hit page is dirty/writable |
| lk_exc | output | 1 | A fault is raised |
| lk_exc_code | output | 3 | 0 none, 1 modify, 2 load, 3 store |
| lk_refill | output | 1 | Fault is a refill (no match) |

## Verification
The hardest case to reach is a lookup where the page size changes which address bits count. With a large page, a tag field carrying stray low bits must still match. An address that differs only in the bit just above the compared range must miss. The odd/even choice also moves to a different address bit. The stimulus loads entries with 16 KB, 64 KB, 1 MB and 64 MB pages and stray low tag bits. It then probes addresses on both sides of each page-pair boundary. It also loads two entries with the same tag and later rewrites the lower one, which exposes the lowest-index priority.

// File: rtl/tlbp_pkg.sv
`timescale 1ns/1ps
package tlbp_pkg;
  localparam int VA_W    = 32;
  localparam int PFN_W   = 24;
  localparam int ASID_W  = 8;
  localparam int MASK_W  = 14;
  localparam int PG_MIN  = 12;
  localparam int VPN2_W  = VA_W - PG_MIN - 1;
  localparam int PA_W    = PFN_W + PG_MIN;
  localparam int SHIFT_W = 5;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_MOD  = 3'd1,
    EXC_LOAD = 3'd2,
    EXC_STOR = 3'd3
  } exc_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn0;
    logic              d0;
    logic              v0;
    logic [PFN_W-1:0]  pfn1;
    logic              d1;
    logic              v1;
  } tlb_ent_t;

  // Page shift from the size field; only 2k contiguous low ones are legal.
  function automatic logic [SHIFT_W-1:0] page_shift(input logic [MASK_W-1:0] m);
    logic [SHIFT_W-1:0] s;
    s = SHIFT_W'(PG_MIN);
    for (int k = 1; k <= MASK_W / 2; k++) begin
      if (m == MASK_W'((1 << (2 * k)) - 1)) s = SHIFT_W'(PG_MIN + 2 * k);
    end
    return s;
  endfunction

  // Tag bits that take part in the comparison for a given shift.
  function automatic logic [VPN2_W-1:0] tag_keep(input logic [SHIFT_W-1:0] sh);
    logic [VPN2_W-1:0] r;
    for (int i = 0; i < VPN2_W; i++) r[i] = ((i + PG_MIN) >= int'(sh));
    return r;
  endfunction

  // Address bits that pass straight through as page offset.
  function automatic logic [PA_W-1:0] offset_keep(input logic [SHIFT_W-1:0] sh);
    logic [PA_W-1:0] r;
    for (int i = 0; i < PA_W; i++) r[i] = (i < int'(sh));
    return r;
  endfunction
endpackage

// File: rtl/tlbp_store.sv
`timescale 1ns/1ps
module tlbp_store
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  tlb_ent_t                      wr_ent,
  output tlb_ent_t [ENTRIES-1:0]        ents
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel_here;
    assign sel_here = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)        ents[g] <= '0;
      else if (sel_here) ents[g] <= wr_ent;
    end
  end

  // R12: a loaded entry holds exactly the written contents one cycle later
  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ents[$past(wr_idx)] == $past(wr_ent));
endmodule

// File: rtl/tlbp_match.sv
`timescale 1ns/1ps
module tlbp_match
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  tlb_ent_t [ENTRIES-1:0]        ents,
  input  logic [VA_W-1:0]               vaddr,
  input  logic [ASID_W-1:0]             asid,
  output logic [ENTRIES-1:0]            match_vec,
  output logic [ENTRIES-1:0][PFN_W-1:0] half_pfn,
  output logic [ENTRIES-1:0]            half_d,
  output logic [ENTRIES-1:0]            half_v,
  output logic [ENTRIES-1:0][PA_W-1:0]  off_mask
);
  logic [VPN2_W-1:0] va_tag;
  assign va_tag = vaddr[VA_W-1:PG_MIN+1];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [SHIFT_W-1:0] sh;
    logic [VPN2_W-1:0]  keep;
    logic               tag_eq;
    logic               asid_ok;
    logic               odd;
    assign sh      = page_shift(ents[g].mask);
    assign keep    = tag_keep(sh);
    assign tag_eq  = ((ents[g].vpn2 ^ va_tag) & keep) == '0;
    assign asid_ok = ents[g].glob || (ents[g].asid == asid);
    assign odd     = vaddr[sh];
    assign match_vec[g] = tag_eq && asid_ok;
    assign half_pfn[g]  = odd ? ents[g].pfn1 : ents[g].pfn0;
    assign half_d[g]    = odd ? ents[g].d1   : ents[g].d0;
    assign half_v[g]    = odd ? ents[g].v1   : ents[g].v0;
    assign off_mask[g]  = offset_keep(sh);
  end
endmodule

// File: rtl/tlbp_resolve.sv
`timescale 1ns/1ps
module tlbp_resolve
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            match_vec,
  input  logic [ENTRIES-1:0][PFN_W-1:0] half_pfn,
  input  logic [ENTRIES-1:0]            half_d,
  input  logic [ENTRIES-1:0]            half_v,
  input  logic [ENTRIES-1:0][PA_W-1:0]  off_mask,
  input  logic [VA_W-1:0]               vaddr,
  input  logic                          lk_write,
  input  logic                          lk_quiet,
  output logic                          lk_hit,
  output logic [PA_W-1:0]               lk_paddr,
  output logic                          lk_writable,
  output logic                          lk_exc,
  output exc_e                          lk_code,
  output logic                          lk_refill
);
  logic [IDX_W-1:0] sel_idx;
  logic             any_match;
  logic             ok_hit;
  logic             fault_inv;
  logic             fault_mod;
  logic             fault_miss;
  logic             sel_d;
  logic             sel_v;

  // Lowest matching index wins: scan from the top down.
  always_comb begin
    sel_idx   = '0;
    any_match = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel_idx   = IDX_W'(i);
        any_match = 1'b1;
      end
    end
  end

  assign sel_d      = half_d[sel_idx];
  assign sel_v      = half_v[sel_idx];
  assign fault_miss = !any_match;
  assign fault_inv  = any_match && !sel_v;
  assign fault_mod  = any_match && sel_v && !sel_d && lk_write;
  assign ok_hit     = !fault_miss && !fault_inv && !fault_mod;

  always_comb begin
    lk_hit      = ok_hit;
    lk_writable = ok_hit && sel_d;
    lk_paddr    = '0;
    if (ok_hit)
      lk_paddr = {half_pfn[sel_idx], {PG_MIN{1'b0}}} | (PA_W'(vaddr) & off_mask[sel_idx]);
    lk_exc    = !ok_hit && !lk_quiet;
    lk_refill = lk_exc && fault_miss;
    lk_code   = EXC_NONE;
    if (lk_exc) begin
      if (fault_mod)     lk_code = EXC_MOD;
      else if (lk_write) lk_code = EXC_STOR;
      else               lk_code = EXC_LOAD;
    end
  end

  // R11: the chosen entry matches and no lower-indexed entry does
  p_lowest_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> (match_vec[sel_idx] &&
                   ((match_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0)));
  // R9: a refill is only ever reported when nothing matched
  p_refill_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_refill |-> (match_vec == '0));
  // R10: quiet lookups never raise a fault
  p_quiet_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_quiet |-> (!lk_exc && !lk_refill && lk_code == EXC_NONE));
  // R8: modification faults come from stores only
  p_mod_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_code == EXC_MOD) |-> (lk_write && !lk_refill));
  // R6: writable is reported only on a hit, and a hit never carries a fault
  p_writable_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_writable |-> lk_hit) and (lk_hit |-> !lk_exc));
endmodule

// File: rtl/tlbp_lookup.sv
`timescale 1ns/1ps
module tlbp_lookup
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic              wr_dirty_even,
  input  logic              wr_valid_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic              wr_dirty_odd,
  input  logic              wr_valid_odd,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_quiet,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_writable,
  output logic              lk_exc,
  output logic [2:0]        lk_exc_code,
  output logic              lk_refill
);
  tlb_ent_t                      wr_ent;
  tlb_ent_t [ENTRIES-1:0]        ents;
  logic [ENTRIES-1:0]            match_vec;
  logic [ENTRIES-1:0][PFN_W-1:0] half_pfn;
  logic [ENTRIES-1:0]            half_d;
  logic [ENTRIES-1:0]            half_v;
  logic [ENTRIES-1:0][PA_W-1:0]  off_mask;
  exc_e                          code;

  always_comb begin
    wr_ent.mask = wr_mask;
    wr_ent.vpn2 = wr_vpn2;
    wr_ent.asid = wr_asid;
    wr_ent.glob = wr_global;
    wr_ent.pfn0 = wr_pfn_even;
    wr_ent.d0   = wr_dirty_even;
    wr_ent.v0   = wr_valid_even;
    wr_ent.pfn1 = wr_pfn_odd;
    wr_ent.d1   = wr_dirty_odd;
    wr_ent.v1   = wr_valid_odd;
  end

  tlbp_store #(.ENTRIES(ENTRIES)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .ents(ents)
  );

  tlbp_match #(.ENTRIES(ENTRIES)) i_match (
    .ents(ents), .vaddr(lk_vaddr), .asid(lk_asid), .match_vec(match_vec),
    .half_pfn(half_pfn), .half_d(half_d), .half_v(half_v), .off_mask(off_mask)
  );

  tlbp_resolve #(.ENTRIES(ENTRIES)) i_resolve (
    .clk(clk), .rst_n(rst_n), .match_vec(match_vec), .half_pfn(half_pfn),
    .half_d(half_d), .half_v(half_v), .off_mask(off_mask), .vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_quiet(lk_quiet), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_writable(lk_writable), .lk_exc(lk_exc),
    .lk_code(code), .lk_refill(lk_refill)
  );

  assign lk_exc_code = code;

  // R7: a fault that is not a refill always carries a code
  p_fault_coded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_exc && !lk_refill) |-> (lk_exc_code != 3'd0));
endmodule

// File: tb/test_tlbp_lookup.sv
`timescale 1ns/1ps
module test_tlbp_lookup;
  import tlbp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [13:0] wr_mask = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0] wr_asid = '0;
  logic wr_global = 1'b0;
  logic [23:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic wr_dirty_even = 1'b0, wr_valid_even = 1'b0;
  logic wr_dirty_odd = 1'b0, wr_valid_odd = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0] lk_asid = '0;
  logic lk_write = 1'b0, lk_quiet = 1'b0;
  logic lk_hit, lk_writable, lk_exc, lk_refill;
  logic [35:0] lk_paddr;
  logic [2:0] lk_exc_code;

  int tests = 0;
  int fails = 0;

  // bench-side copy of loaded entries
  logic [13:0] m_mask [N];
  logic [18:0] m_vpn2 [N];
  logic [7:0]  m_asid [N];
  logic        m_glob [N];
  logic [23:0] m_p0 [N], m_p1 [N];
  logic        m_d0 [N], m_v0 [N], m_d1 [N], m_v1 [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbp_lookup #(.ENTRIES(N)) i_tlbp_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn_even(wr_pfn_even), .wr_dirty_even(wr_dirty_even), .wr_valid_even(wr_valid_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_dirty_odd(wr_dirty_odd), .wr_valid_odd(wr_valid_odd),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write), .lk_quiet(lk_quiet),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_writable(lk_writable), .lk_exc(lk_exc),
    .lk_exc_code(lk_exc_code), .lk_refill(lk_refill)
  );

  // R2 restated: length of the low run of ones, accepted only if even and nothing above it
  function automatic int shift_of(input logic [13:0] m);
    int run = 0;
    for (int i = 0; i < 14; i++) if (m[i] && run == i) run = i + 1;
    if ((m >> run) != 0 || (run % 2) != 0) return 12;
    return 12 + run;
  endfunction

  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                       input logic quiet, output logic eh, output logic [35:0] ep,
                       output logic ew, output logic ee, output logic [2:0] ec,
                       output logic er);
    int found = -1;
    int sh = 12;
    logic odd, d, v;
    logic [23:0] pfn;
    for (int i = 0; i < N; i++) begin
      int s = shift_of(m_mask[i]);
      if (found < 0 && (va >> (s + 1)) == (32'(m_vpn2[i]) >> (s - 12)) &&
          (m_glob[i] || m_asid[i] == asid)) begin
        found = i;
        sh = s;
      end
    end
    eh = 0; ep = '0; ew = 0; ee = 0; ec = 3'd0; er = 0;
    if (found < 0) begin
      ee = !quiet; er = !quiet; ec = quiet ? 3'd0 : (wr ? 3'd3 : 3'd2);
    end else begin
      odd = va[sh];
      pfn = odd ? m_p1[found] : m_p0[found];
      d   = odd ? m_d1[found] : m_d0[found];
      v   = odd ? m_v1[found] : m_v0[found];
      if (!v) begin
        ee = !quiet; ec = quiet ? 3'd0 : (wr ? 3'd3 : 3'd2);
      end else if (wr && !d) begin
        ee = !quiet; ec = quiet ? 3'd0 : 3'd1;
      end else begin
        eh = 1; ew = d;
        ep = {pfn, 12'h000} | (36'(va) & ((36'd1 << sh) - 36'd1));
      end
    end
  endtask

  task automatic load(input int idx, input logic [13:0] m, input logic [18:0] vpn2,
                      input logic [7:0] asid, input logic g,
                      input logic [23:0] p0, input logic d0, input logic v0,
                      input logic [23:0] p1, input logic d1, input logic v1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_mask = m; wr_vpn2 = vpn2; wr_asid = asid;
    wr_global = g; wr_pfn_even = p0; wr_dirty_even = d0; wr_valid_even = v0;
    wr_pfn_odd = p1; wr_dirty_odd = d1; wr_valid_odd = v1;
    @(posedge clk);
    #1 wr_en = 0;
    m_mask[idx] = m; m_vpn2[idx] = vpn2; m_asid[idx] = asid; m_glob[idx] = g;
    m_p0[idx] = p0; m_d0[idx] = d0; m_v0[idx] = v0;
    m_p1[idx] = p1; m_d1[idx] = d1; m_v1[idx] = v1;
  endtask

  task automatic probe(input string tag, input logic [31:0] va, input logic [7:0] asid,
                       input logic wr, input logic quiet);
    logic eh, ew, ee, er;
    logic [35:0] ep;
    logic [2:0] ec;
    @(negedge clk);
    lk_vaddr = va; lk_asid = asid; lk_write = wr; lk_quiet = quiet;
    #1;
    model(va, asid, wr, quiet, eh, ep, ew, ee, ec, er);
    tests++;
    if ({lk_hit, lk_paddr, lk_writable, lk_exc, lk_exc_code, lk_refill} !==
        {eh, ep, ew, ee, ec, er}) begin
      fails++;
      $display("FAIL %s va=%h: got hit=%0b pa=%h wb=%0b exc=%0b code=%0d refill=%0b, expected hit=%0b pa=%h wb=%0b exc=%0b code=%0d refill=%0b",
               tag, va, lk_hit, lk_paddr, lk_writable, lk_exc, lk_exc_code, lk_refill,
               eh, ep, ew, ee, ec, er);
    end
  endtask

  // literal check that does not rely on the model
  task automatic expect_code(input string tag, input logic [2:0] code, input logic refill);
    tests++;
    if (lk_exc_code !== code || lk_refill !== refill) begin
      fails++;
      $display("FAIL %s: got code=%0d refill=%0b, expected code=%0d refill=%0b",
               tag, lk_exc_code, lk_refill, code, refill);
    end
  endtask

  task automatic t_reset_r1();
    probe("R1 reset read", 32'h0000_0123, 8'h00, 0, 0);
    expect_code("R1 reset read code", 3'd2, 1'b0);
    probe("R1 reset store", 32'h0000_0123, 8'h00, 1, 0);
    expect_code("R1 reset store code", 3'd3, 1'b0);
  endtask

  task automatic t_basic_r6_r4();
    load(1, 14'h0, 19'h00012, 8'h05, 0, 24'hABCDE, 1, 1, 24'h11111, 0, 1);
    probe("R6 even hit dirty", {19'h00012, 1'b0, 12'h345}, 8'h05, 0, 0);
    probe("R4 odd half clean", {19'h00012, 1'b1, 12'hFFF}, 8'h05, 0, 0);
    probe("R6 store even", {19'h00012, 1'b0, 12'h001}, 8'h05, 1, 0);
  endtask

  task automatic t_sizes_r2();
    load(4, 14'h0003, 19'h00400, 8'h05, 0, 24'h00400, 1, 1, 24'h00500, 1, 1);
    probe("R2 16K odd", (32'h400 << 13) | 32'h4000 | 32'h2ABC, 8'h05, 0, 0);
    probe("R2 16K even", (32'h400 << 13) | 32'h3FFF, 8'h05, 0, 0);
    load(5, 14'h00FF, 19'h10000, 8'h00, 1, 24'h0F000, 1, 1, 24'h0E000, 0, 1);
    probe("R2 1M even", 32'h2000_0000 | 32'h7FFFF, 8'h44, 0, 0);
    probe("R2 1M odd", 32'h2010_0000 | 32'h12345, 8'h44, 0, 0);
    load(6, 14'h3FFF, 19'h40000, 8'h00, 1, 24'h100000, 1, 1, 24'h200000, 1, 1);
    probe("R2 64M odd", 32'h8400_0000 | 32'h0123456, 8'h01, 1, 0);
    probe("R2 64M even", 32'h8000_0000 | 32'h3FFFFFF, 8'h01, 0, 0);
  endtask

  task automatic t_tag_r3();
    load(7, 14'h000F, 19'h0230F, 8'h05, 0, 24'h00777, 1, 1, 24'h00888, 1, 1);
    probe("R3 low tag bits ignored", 32'h0460_0000 | 32'h1E000, 8'h05, 0, 0);
    probe("R3 bit above shift compared", 32'h0462_0000, 8'h05, 0, 0);
    probe("R3 odd at bit 16", 32'h0461_0000, 8'h05, 0, 0);
  endtask

  task automatic t_asid_r5();
    probe("R5 asid mismatch", {19'h00012, 1'b0, 12'h345}, 8'h06, 0, 0);
    load(8, 14'h0, 19'h00777, 8'h33, 1, 24'h00ABC, 1, 1, 24'h0, 0, 0);
    probe("R5 global any asid", {19'h00777, 1'b0, 12'h010}, 8'h99, 0, 0);
  endtask

  task automatic t_faults_r7_r8();
    load(10, 14'h0, 19'h00900, 8'h05, 0, 24'h01000, 1, 0, 24'h02000, 0, 1);
    probe("R7 invalid read", {19'h00900, 1'b0, 12'h000}, 8'h05, 0, 0);
    expect_code("R7 invalid read code", 3'd2, 1'b0);
    probe("R7 invalid store", {19'h00900, 1'b0, 12'h004}, 8'h05, 1, 0);
    expect_code("R7 invalid store code", 3'd3, 1'b0);
    probe("R8 modify", {19'h00900, 1'b1, 12'h008}, 8'h05, 1, 0);
    expect_code("R8 modify code", 3'd1, 1'b0);
    probe("R8 clean read hits", {19'h00900, 1'b1, 12'h008}, 8'h05, 0, 0);
  endtask

  task automatic t_miss_r9();
    probe("R9 miss read", 32'h7FFF_E000, 8'h05, 0, 0);
    expect_code("R9 miss read code", 3'd2, 1'b1);
    probe("R9 miss store", 32'h7FFF_E000, 8'h05, 1, 0);
    expect_code("R9 miss store code", 3'd3, 1'b1);
  endtask

  task automatic t_quiet_r10();
    probe("R10 quiet miss", 32'h7FFF_E000, 8'h05, 1, 1);
    probe("R10 quiet invalid", {19'h00900, 1'b0, 12'h000}, 8'h05, 0, 1);
    probe("R10 quiet modify", {19'h00900, 1'b1, 12'h000}, 8'h05, 1, 1);
    probe("R10 quiet hit", {19'h00012, 1'b0, 12'h345}, 8'h05, 0, 1);
  endtask

  task automatic t_priority_r11_r12();
    load(9, 14'h0, 19'h00AAA, 8'h05, 0, 24'h00999, 1, 1, 24'h00999, 1, 1);
    load(3, 14'h0, 19'h00AAA, 8'h05, 0, 24'h00333, 1, 1, 24'h00333, 1, 1);
    probe("R11 lowest index wins", {19'h00AAA, 1'b0, 12'h0AB}, 8'h05, 0, 0);
    tests++;
    if (lk_paddr[35:12] !== 24'h00333) begin
      fails++;
      $display("FAIL R11 frame: got %h expected %h", lk_paddr[35:12], 24'h00333);
    end
    load(3, 14'h0, 19'h00BBB, 8'h05, 0, 24'h00444, 0, 1, 24'h0, 0, 0);
    probe("R12 overwrite exposes next", {19'h00AAA, 1'b0, 12'h0AB}, 8'h05, 0, 0);
    probe("R12 new tag live", {19'h00BBB, 1'b0, 12'h0CD}, 8'h05, 0, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mask[i] = '0; m_vpn2[i] = '0; m_asid[i] = '0; m_glob[i] = 0;
      m_p0[i] = '0; m_p1[i] = '0; m_d0[i] = 0; m_v0[i] = 0; m_d1[i] = 0; m_v1[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r1();
    t_basic_r6_r4();
    t_sizes_r2();
    t_tag_r3();
    t_asid_r5();
    t_faults_r7_r8();
    t_miss_r9();
    t_quiet_r10();
    t_priority_r11_r12();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end
endmodule